// File: doc/BRIEF.md
# Burst Read Prefetch Bridge

This block sits between a Wishbone B3 slave port and a pipelined memory-mapped master port. The pipelined side has separate read and write command strobes, a waitrequest stall, and a readdatavalid return. The bridge does not turn incoming bursts into fixed-length bursts on the far side. It generates addresses instead. When the Wishbone master starts a linear incrementing burst, the bridge posts a window of word reads ahead of the master. It then hands the returned words back one Wishbone beat at a time.

Wishbone linear bursts carry no length, so the prefetch is speculative. If the master ends the burst early, the bridge stops issuing. Responses that are still in flight are absorbed without producing an acknowledge. The next access begins only after every such response has arrived. Writes are passed through one at a time.

Top module: `burst_read_bridge`

## Requirements
- R1: While reset is asserted and after its release with no request, neither `pm_read_o` nor `pm_write_o` is high and `wb_ack_o` is low.
- R2: A read whose `wb_cti_i` is 3'b000 (classic) or 3'b111 (end of burst) issues exactly one pipelined read at `wb_adr_i`. The word returned for it appears on `wb_dat_o` together with `wb_ack_o`.
- R3: A read with `wb_cti_i` = 3'b010 and `wb_bte_i` = 2'b00 (linear burst) posts up to WIN (default 8) pipelined reads at the start address and at successive addresses 4 bytes apart. More than one read is already posted by the time the first beat is acknowledged.
- R4: Burst beats are acknowledged in issue order, and each acknowledged beat carries the word read at its own address.
- R5: Once `wb_cyc_i` falls during a burst, no further read command is issued. The only exception is a command already stalled by waitrequest, which is held until it is taken.
- R6: Responses to reads posted before an abort produce no `wb_ack_o`. A following access is not started until all of them have returned, so it receives its own data.
- R7: A write issues exactly one pipelined write carrying the Wishbone address, data and byte selects. `wb_ack_o` rises in the cycle after the command is taken. With no stall, the ack is seen in the second clock cycle after the request is first sampled.
- R8: While waitrequest is high, an issued read or write command, with its address and data, stays unchanged until the command is taken.
- R9: `wb_ack_o` is high for one clock per completed beat. An access is accepted only when `wb_cyc_i` and `wb_stb_i` are both high and no ack is being driven.
- R10: When a beat tagged 3'b111 is acknowledged, prefetched words beyond it are dropped and no further ack follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | AW | Wishbone byte address |
| wb_dat_i | input | DW | Wishbone write data |
| wb_sel_i | input | DW/8 | Wishbone byte selects |
| wb_cti_i | input | 3 | Cycle type tag |
| wb_bte_i | input | 2 | Burst type tag |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| wb_dat_o | output | DW | Wishbone read data |
| pm_read_o | output | 1 | Pipelined read command |
| pm_write_o | output | 1 | Pipelined write command |
| pm_addr_o | output | AW | Pipelined command address |
| pm_wdata_o | output | DW | Pipelined write data |
| pm_be_o | output | DW/8 | Pipelined byte enables |
| pm_waitreq_i | input | 1 | Pipelined stall |
| pm_rdata_i | input | DW | Pipelined read data |
| pm_rvalid_i | input | 1 | Pipelined read data valid |

## Verification
The bench aborts a burst and then starts a classic read at once, while discarded responses are still in flight. A bridge that did not wait for them would hand a stale prefetched word to the new read. It runs bursts that end on the 3'b111 tag and bursts longer than the window. A bridge that kept acknowledging after the tag, or lost its place at the window boundary, would return extra acks or wrong words. It aborts under heavy waitrequest and checks that the read count freezes. A bridge that kept prefetching after `wb_cyc_i` fell would keep adding reads. It also holds `wb_cyc_i` without `wb_stb_i`, and measures write ack latency to catch a missing or doubled wait state.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_DRAIN,
    ST_WR,
    ST_WACK
  } bt_state_e;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_END     = 3'b111;
  localparam logic [1:0] BTE_LINEAR  = 2'b00;
endpackage

// File: rtl/bt_rd_fifo.sv
module bt_rd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CNW = $clog2(DEPTH + 1);

  logic [DW-1:0]  mem_q [DEPTH];
  logic [PW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           do_push, do_pop;

  assign do_push = push_i && !flush_i;
  assign do_pop  = pop_i && !flush_i;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNW'(DEPTH));

  // R3: the window never holds more words than the buffer can take
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && !flush_i && full_o && !pop_i));
  // R4: a beat is only handed back when a word is waiting
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o));
endmodule

// File: rtl/bt_inflight.sv
module bt_inflight #(
  parameter int CW  = 4,
  parameter int MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc_i, dec_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R6: every response matches a posted read
  a_r6_no_stray_response: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0 || inc_i));
  // R3: at most one window of reads is in flight
  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX));
endmodule

// File: rtl/burst_read_bridge.sv
module burst_read_bridge
  import bt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int WIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_cyc_i,
  input  logic            wb_stb_i,
  input  logic            wb_we_i,
  input  logic [AW-1:0]   wb_adr_i,
  input  logic [DW-1:0]   wb_dat_i,
  input  logic [DW/8-1:0] wb_sel_i,
  input  logic [2:0]      wb_cti_i,
  input  logic [1:0]      wb_bte_i,
  output logic            wb_ack_o,
  output logic [DW-1:0]   wb_dat_o,
  output logic            pm_read_o,
  output logic            pm_write_o,
  output logic [AW-1:0]   pm_addr_o,
  output logic [DW-1:0]   pm_wdata_o,
  output logic [DW/8-1:0] pm_be_o,
  input  logic            pm_waitreq_i,
  input  logic [DW-1:0]   pm_rdata_i,
  input  logic            pm_rvalid_i
);
  localparam int BW = DW / 8;
  localparam int SH = $clog2(BW);
  localparam int CW = $clog2(WIN + 1);

  bt_state_e     st_q, st_d;
  logic [AW-1:0] base_q;
  logic [DW-1:0] wdat_q, dat_q;
  logic [BW-1:0] sel_q;
  logic [CW-1:0] issued_q, limit_q, infl_cnt;
  logic          hold_q, stop_q, ack_q;
  logic          req_ok, is_burst, abort_now, abort_eff, more;
  logic          rd_cmd, rd_go, wr_go, ack_d, done_rd, flush;
  logic          ff_push, ff_empty, ff_full, infl_zero;
  logic [DW-1:0] ff_head;

  // Request qualification and issue control
  assign req_ok    = wb_cyc_i && wb_stb_i && !ack_q;
  assign is_burst  = (wb_cti_i == CTI_INCR) && (wb_bte_i == BTE_LINEAR);
  assign abort_now = !wb_cyc_i || (ack_q && wb_cti_i == CTI_END);
  assign abort_eff = abort_now || stop_q;
  assign more      = issued_q < limit_q;
  assign rd_cmd    = (st_q == ST_RD) && more && (!abort_eff || hold_q);
  assign rd_go     = rd_cmd && !pm_waitreq_i;
  assign wr_go     = (st_q == ST_WR) && !pm_waitreq_i;
  assign ack_d     = (st_q == ST_RD) && !abort_eff && req_ok && !ff_empty;
  assign ff_push   = pm_rvalid_i && (st_q == ST_RD) && !abort_eff;
  assign done_rd   = !more && infl_zero && ff_empty;

  bt_rd_fifo #(.DW(DW), .DEPTH(WIN)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(ff_push), .data_i(pm_rdata_i),
    .pop_i(ack_d), .flush_i(flush),
    .head_o(ff_head), .empty_o(ff_empty), .full_o(ff_full)
  );

  bt_inflight #(.CW(CW), .MAX(WIN)) u_inflight (
    .clk(clk), .rst_n(rst_n),
    .inc_i(rd_go), .dec_i(pm_rvalid_i),
    .cnt_o(infl_cnt), .zero_o(infl_zero)
  );

  // Next state
  always_comb begin
    st_d  = st_q;
    flush = 1'b0;
    case (st_q)
      ST_IDLE:  if (req_ok && infl_zero) st_d = wb_we_i ? ST_WR : ST_RD;
      ST_RD: begin
        if (abort_eff && !(rd_cmd && pm_waitreq_i)) begin
          st_d  = ST_DRAIN;
          flush = 1'b1;
        end else if (done_rd && !abort_eff) begin
          st_d = ST_IDLE;
        end
      end
      ST_DRAIN: if (infl_zero) st_d = ST_IDLE;
      ST_WR:    if (!pm_waitreq_i) st_d = ST_WACK;
      ST_WACK:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      wdat_q   <= '0;
      sel_q    <= '0;
      issued_q <= '0;
      limit_q  <= '0;
      hold_q   <= 1'b0;
      stop_q   <= 1'b0;
      ack_q    <= 1'b0;
      dat_q    <= '0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d || wr_go;
      hold_q <= rd_cmd && pm_waitreq_i;
      if (ack_d) dat_q <= ff_head;
      if (st_q == ST_IDLE && st_d != ST_IDLE) begin
        base_q   <= wb_adr_i;
        wdat_q   <= wb_dat_i;
        sel_q    <= wb_sel_i;
        issued_q <= '0;
        limit_q  <= (!wb_we_i && is_burst) ? CW'(WIN) : CW'(1);
        stop_q   <= 1'b0;
      end else begin
        if (rd_go) issued_q <= issued_q + 1'b1;
        if (st_q == ST_RD && abort_now) stop_q <= 1'b1;
      end
    end
  end

  assign pm_read_o  = rd_cmd;
  assign pm_write_o = (st_q == ST_WR);
  assign pm_addr_o  = (st_q == ST_WR) ? base_q : base_q + (AW'(issued_q) << SH);
  assign pm_wdata_o = wdat_q;
  assign pm_be_o    = (st_q == ST_WR) ? sel_q : '1;
  assign wb_ack_o   = ack_q;
  assign wb_dat_o   = dat_q;

  // R1: an idle bridge drives no command
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!pm_read_o && !pm_write_o));
  // R8: stalled read stays put
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_read_o && pm_waitreq_i) |=> (pm_read_o && $stable(pm_addr_o)));
  // R8: stalled write stays put
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_write_o && pm_waitreq_i) |=>
      (pm_write_o && $stable(pm_addr_o) && $stable(pm_wdata_o) && $stable(pm_be_o)));
  // R9: one ack clock per beat
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);
  // R5: no new read once the master has left the cycle
  a_r5_stop_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_cyc_i && !hold_q) |-> !pm_read_o);
  // R6: a new access starts only with nothing in flight
  a_r6_idle_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (infl_cnt == '0));
endmodule

// File: tb/burst_read_bridge_bench.sv
module burst_read_bridge_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat;
  logic [3:0] wb_sel;
  logic [2:0] wb_cti;
  logic [1:0] wb_bte;
  logic wb_ack_o;
  logic [DW-1:0] wb_dat_o;
  logic pm_read_o, pm_write_o;
  logic [AW-1:0] pm_addr_o;
  logic [DW-1:0] pm_wdata_o;
  logic [3:0] pm_be_o;
  logic pm_waitreq_i, pm_rvalid_i;
  logic [DW-1:0] pm_rdata_i;

  always #4 clk = ~clk;

  burst_read_bridge #(.AW(AW), .DW(DW), .WIN(WIN)) u_burst_read_bridge (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_dat), .wb_sel_i(wb_sel), .wb_cti_i(wb_cti), .wb_bte_i(wb_bte),
    .wb_ack_o(wb_ack_o), .wb_dat_o(wb_dat_o),
    .pm_read_o(pm_read_o), .pm_write_o(pm_write_o), .pm_addr_o(pm_addr_o),
    .pm_wdata_o(pm_wdata_o), .pm_be_o(pm_be_o), .pm_waitreq_i(pm_waitreq_i),
    .pm_rdata_i(pm_rdata_i), .pm_rvalid_i(pm_rvalid_i)
  );

  function automatic logic [31:0] mdl(input logic [31:0] a);
    return a ^ 32'hC3A5_0F1E;
  endfunction

  // Pipelined memory model: fixed three-cycle read latency, optional stall
  logic stall_en = 1'b0;
  logic [1:0] ph;
  logic v0, v1, v2;
  logic [AW-1:0] a0, a1, a2;
  int rd_n, wr_n, ack_n;
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;

  assign pm_waitreq_i = stall_en && (ph != 2'd3);
  assign pm_rvalid_i  = v2;
  assign pm_rdata_i   = v2 ? mdl(a2) : '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0;
      a0 <= '0; a1 <= '0; a2 <= '0;
      rd_n <= 0; wr_n <= 0; last_wa <= '0; last_wd <= '0;
    end else begin
      ph <= ph + 1'b1;
      v0 <= pm_read_o && !pm_waitreq_i;
      a0 <= pm_addr_o;
      v1 <= v0; a1 <= a0;
      v2 <= v1; a2 <= a1;
      if (pm_read_o && !pm_waitreq_i) begin
        rd_log[rd_n[5:0]] <= pm_addr_o;
        rd_n <= rd_n + 1;
      end
      if (pm_write_o && !pm_waitreq_i) begin
        last_wa <= pm_addr_o;
        last_wd <= pm_wdata_o;
        wr_n <= wr_n + 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitors sampled at the falling edge
  logic prev_rh = 1'b0, prev_wh = 1'b0, prev_ack = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rh) chk(pm_read_o && pm_addr_o == prev_addr, "R8 read hold", pm_addr_o, prev_addr);
      if (prev_wh) chk(pm_write_o && pm_addr_o == prev_addr && pm_wdata_o == prev_wd,
                       "R8 write hold", pm_wdata_o, prev_wd);
      if (prev_ack) chk(!wb_ack_o, "R9 single ack clock", 32'(wb_ack_o), 32'd0);
      if (wb_ack_o) ack_n++;
    end
    prev_rh   = rst_n && pm_read_o && pm_waitreq_i;
    prev_wh   = rst_n && pm_write_o && pm_waitreq_i;
    prev_ack  = rst_n && wb_ack_o;
    prev_addr = pm_addr_o;
    prev_wd   = pm_wdata_o;
  end

  task automatic wb_idle();
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0; wb_cti = 3'b000; wb_bte = 2'b00;
  endtask

  task automatic wb_single(input bit we, input logic [31:0] adr, input logic [31:0] dat,
                           input logic [2:0] cti, output logic [31:0] rdat, output int waits);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat = dat;
    wb_sel = 4'hF; wb_cti = cti; wb_bte = 2'b00;
    waits = 0;
    do begin @(negedge clk); waits++; end while (!wb_ack_o && waits < 300);
    rdat = wb_dat_o;
    @(negedge clk);
    wb_idle();
  endtask

  int first_rd;
  task automatic wb_burst(input logic [31:0] adr, input int beats, input bit end_tag);
    int w;
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_bte = 2'b00; wb_sel = 4'hF;
    wb_adr = adr; wb_cti = (end_tag && beats == 1) ? 3'b111 : 3'b010;
    for (int i = 0; i < beats; i++) begin
      w = 0;
      do begin @(negedge clk); w++; end while (!wb_ack_o && w < 300);
      if (i == 0) first_rd = rd_n;
      chk(wb_ack_o && wb_dat_o == mdl(adr + 32'(4 * i)), "R4 burst beat data",
          wb_dat_o, mdl(adr + 32'(4 * i)));
      @(negedge clk);
      if (i < beats - 1) begin
        wb_adr = adr + 32'(4 * (i + 1));
        wb_cti = (end_tag && i == beats - 2) ? 3'b111 : 3'b010;
      end
    end
    wb_idle();
  endtask

  // Stimulus table: {stall, we, address, write data}
  localparam logic [65:0] VEC [6] = '{
    {1'b0, 1'b1, 32'h0000_0100, 32'hDEAD_BEEF},
    {1'b0, 1'b0, 32'h0000_0200, 32'h0000_0000},
    {1'b1, 1'b1, 32'h0000_0344, 32'h1234_5678},
    {1'b1, 1'b0, 32'h0000_0408, 32'h0000_0000},
    {1'b0, 1'b0, 32'h0000_0FFC, 32'h0000_0000},
    {1'b0, 1'b1, 32'h0000_0010, 32'hA5A5_5A5A}
  };

  initial begin
    int rd0, wr0, ak0, rda, waits;
    logic [31:0] rdat;
    bit ok;
    wb_idle(); wb_adr = '0; wb_dat = '0; wb_sel = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!pm_read_o && !pm_write_o && !wb_ack_o, "R1 reset quiet",
        {29'd0, pm_read_o, pm_write_o, wb_ack_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pm_read_o && !pm_write_o && !wb_ack_o && rd_n == 0, "R1 idle after reset",
        32'(rd_n), 32'd0);

    // Table walk: classic reads and writes
    for (int k = 0; k < 6; k++) begin
      stall_en = VEC[k][65];
      rd0 = rd_n; wr0 = wr_n;
      wb_single(VEC[k][64], VEC[k][63:32], VEC[k][31:0], 3'b000, rdat, waits);
      if (VEC[k][64]) begin
        chk(wr_n == wr0 + 1 && rd_n == rd0, "R7 one write", 32'(wr_n - wr0), 32'd1);
        chk(last_wa == VEC[k][63:32], "R7 write address", last_wa, VEC[k][63:32]);
        chk(last_wd == VEC[k][31:0], "R7 write data", last_wd, VEC[k][31:0]);
        if (!VEC[k][65]) chk(waits == 2, "R7 write wait state", 32'(waits), 32'd2);
      end else begin
        chk(rdat == mdl(VEC[k][63:32]), "R2 classic data", rdat, mdl(VEC[k][63:32]));
        chk(rd_n == rd0 + 1 && rd_log[rd0[5:0]] == VEC[k][63:32], "R2 single read",
            32'(rd_n - rd0), 32'd1);
      end
    end
    stall_en = 1'b0;

    // R2: end-of-burst tag alone is a single read
    rd0 = rd_n;
    wb_single(1'b0, 32'h0000_0520, 32'h0, 3'b111, rdat, waits);
    repeat (8) @(negedge clk);
    chk(rd_n == rd0 + 1 && rdat == mdl(32'h520), "R2 end-tag single", 32'(rd_n - rd0), 32'd1);

    // R3/R10: short burst with end tag, full window prefetched then dropped
    rd0 = rd_n;
    wb_burst(32'h0000_1000, 4, 1'b1);
    chk(first_rd - rd0 > 1, "R3 reads posted ahead of first ack", 32'(first_rd - rd0), 32'd2);
    ak0 = ack_n;
    repeat (20) @(negedge clk);
    chk(rd_n - rd0 == WIN, "R3 window size", 32'(rd_n - rd0), 32'(WIN));
    ok = 1'b1;
    for (int i = 0; i < WIN; i++)
      if (rd_log[(rd0 + i) % 64] != 32'h1000 + 32'(4 * i)) ok = 1'b0;
    chk(ok, "R3 successive addresses", 32'(ok), 32'd1);
    chk(ack_n == ak0, "R10 no ack after end tag", 32'(ack_n - ak0), 32'd0);

    // R3/R10: burst longer than the window
    rd0 = rd_n;
    wb_burst(32'h0000_2000, 10, 1'b1);
    ak0 = ack_n;
    repeat (20) @(negedge clk);
    chk(rd_n - rd0 >= 10 && rd_n - rd0 <= 2 * WIN, "R3 second window", 32'(rd_n - rd0), 32'd16);
    chk(rd_log[(rd0 + 8) % 64] == 32'h2020, "R3 second window start",
        rd_log[(rd0 + 8) % 64], 32'h2020);
    chk(ack_n == ak0, "R10 no ack after long burst", 32'(ack_n - ak0), 32'd0);

    // R5/R6: abort under heavy stall
    stall_en = 1'b1;
    rd0 = rd_n; ak0 = ack_n;
    wb_burst(32'h0000_3000, 1, 1'b0);
    ak0 = ack_n;
    repeat (5) @(negedge clk);
    rda = rd_n;
    repeat (30) @(negedge clk);
    chk(rd_n == rda, "R5 no reads after drop", 32'(rd_n), 32'(rda));
    chk(rda - rd0 < WIN, "R5 window cut short", 32'(rda - rd0), 32'(WIN));
    chk(ack_n == ak0, "R6 no ack for discarded", 32'(ack_n - ak0), 32'd0);
    stall_en = 1'b0;

    // R6: abort then immediate new read while responses are in flight
    wb_burst(32'h0000_4000, 2, 1'b0);
    rd0 = rd_n;
    wb_single(1'b0, 32'h0000_5000, 32'h0, 3'b000, rdat, waits);
    chk(rdat == mdl(32'h5000), "R6 fresh data after abort", rdat, mdl(32'h5000));
    repeat (8) @(negedge clk);
    chk(rd_log[(rd_n - 1) % 64] == 32'h5000, "R6 new read address",
        rd_log[(rd_n - 1) % 64], 32'h5000);

    // R9: cycle without strobe is not accepted
    rd0 = rd_n; wr0 = wr_n; ak0 = ack_n;
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b0; wb_we = 1'b1; wb_adr = 32'h600;
    repeat (10) @(negedge clk);
    chk(rd_n == rd0 && wr_n == wr0 && ack_n == ak0 && !pm_write_o, "R9 no strobe ignored",
        32'(wr_n - wr0), 32'd0);
    wb_idle();
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule